// File: doc/BRIEF.md
# Write-back data cache with block maintenance commands

This block is a small direct-mapped, write-back data cache that sits between a processor's request port and a line-wide memory port. Besides ordinary word loads and stores (write-allocate), it carries out block-level maintenance commands issued on the same port:

- a prefetch hint (touch);
- zero-block;
- clean, which writes a modified block back;
- flush, which writes back and then invalidates.

The block also holds a separate tag array on the instruction side. Two commands act on that array. One probes it and allocates the block on a miss. The other invalidates the addressed block.

The processor presents one request at a time. A request is accepted when `req_valid` is high while `busy` is low. `busy` then stays high until the command completes, and completion is marked by a one-cycle `rsp_valid` pulse. On that pulse `rsp_hit` reports whether the addressed block was present when the command looked it up. For loads, `rsp_rdata` carries the word.

Memory traffic uses whole 16-byte lines. The cache raises `mem_req` with `mem_we`, `mem_addr` and `mem_wdata`, and holds them until the memory returns a one-cycle `mem_ack`. On a read, `mem_ack` comes with `mem_rdata`.

Top module: `dcache_maint`

## Requirements
- R1: After synchronous reset, `busy`, `rsp_valid` and `mem_req` are low and every data and instruction block is invalid, so the first access to any block misses.
- R2: A request is taken on a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle until completion. Completion is a single-cycle `rsp_valid` pulse during which `busy` is already low.
- R3: Load (`req_op`=0) returns the 32-bit word selected by address bits [3:2]. On a miss it reads the whole line from memory and reports `rsp_hit`=0. On a hit it makes no memory access and reports `rsp_hit`=1.
- R4: Store (`req_op`=1) writes the word into the cached line, allocating the line on a miss by reading it first, and marks the line modified. A later load of the same word returns the stored value.
- R5: A miss that must replace a modified line first writes that line to its own line address (`mem_we`=1) and only then reads the new line. Replacing an unmodified line causes no write.
- R6: Touch (`req_op`=2) brings a missing line in from memory but does not mark it modified. Its later replacement causes no memory write.
- R7: Zero-block (`req_op`=3) makes all 16 bytes of the block zero and marks it modified, without reading memory, on a hit and on a miss alike.
- R8: Clean (`req_op`=4) on a modified present block writes it to memory once, leaving it present and unmodified. On an unmodified or absent block it causes no memory traffic.
- R9: Flush (`req_op`=5) writes a modified present block to memory and then invalidates it. An unmodified present block is invalidated with no write. In both cases the next access to the block misses.
- R10: Instruction probe (`req_op`=7) reports whether the block is in the instruction tag array and allocates it if not. Instruction invalidate (`req_op`=6) reports presence the same way and removes the block. Neither command touches the memory port or the data cache.
- R11: `mem_req` is only high while `busy` is high. Once raised, it stays high with an unchanged line-aligned address until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Command code (0 load, 1 store, 2 touch, 3 zero, 4 clean, 5 flush, 6 instruction invalidate, 7 instruction probe) |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| busy | output | 1 | Command in progress, no request taken |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data |
| rsp_hit | output | 1 | Addressed block was present at lookup |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 write-back, 0 line read |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Line written back |
| mem_ack | input | 1 | Transfer done, one cycle |
| mem_rdata | input | 128 | Line read data, valid with `mem_ack` |

## Verification
The assertions assume that `mem_ack` is a single-cycle pulse that only arrives while `mem_req` is high. They also assume that `req_valid` carries its request only until the edge that takes it. The memory model in the bench answers a transfer only after it has seen `mem_req` for three cycles, and then pulses `mem_ack` once. The request tasks raise `req_valid` only while `busy` is low and drop it right after the accepting edge. The tests use separate cache indices, so each scenario starts from a known line state.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_TOUCH  = 3'd2,
    OP_ZERO   = 3'd3,
    OP_CLEAN  = 3'd4,
    OP_FLUSH  = 3'd5,
    OP_IINV   = 3'd6,
    OP_IPROBE = 3'd7
  } dcm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL
  } dcm_state_e;
endpackage

// File: rtl/dcm_tag_store.sv
module dcm_tag_store #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 24,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_valid
);
  logic [TAG_W-1:0]   tags [ENTRIES];
  logic [ENTRIES-1:0] vbits;

  always_ff @(posedge clk) begin
    if (rst) vbits <= '0;
    else if (wr_en) vbits[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tags[wr_idx] <= wr_tag;
  end

  assign rd_tag   = tags[rd_idx];
  assign rd_valid = vbits[rd_idx];
endmodule

// File: rtl/dcm_line_ram.sv
module dcm_line_ram #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcm_word_merge.sv
module dcm_word_merge #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [WORDS*WORD_W-1:0] line_in,
  input  logic [WORD_W-1:0]       word_in,
  input  logic [SEL_W-1:0]        sel,
  input  logic                    en,
  output logic [WORDS*WORD_W-1:0] line_out
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign line_out[w*WORD_W +: WORD_W] =
      (en && sel == SEL_W'(w)) ? word_in : line_in[w*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/dcache_maint.sv
module dcache_maint
  import dcm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int LINES      = 16,
  parameter int ILINES     = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [2:0]              req_op,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [31:0]             req_wdata,
  output logic                    busy,
  output logic                    rsp_valid,
  output logic [31:0]             rsp_rdata,
  output logic                    rsp_hit,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  input  logic                    mem_ack,
  input  logic [LINE_BYTES*8-1:0] mem_rdata
);
  localparam int WORD_W = 32;
  localparam int WORDS  = LINE_BYTES / 4;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int IIDX_W = $clog2(ILINES);
  localparam int ITAG_W = ADDR_W - IIDX_W - OFF_W;
  localparam int SEL_W  = (WORDS > 1) ? $clog2(WORDS) : 1;

  dcm_state_e         st;
  dcm_op_e            op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [WORD_W-1:0]  wdata_q;
  logic [LINES-1:0]   dirty_q;

  logic [IDX_W-1:0]   idx_q;
  logic [TAG_W-1:0]   tag_q;
  logic [IIDX_W-1:0]  iidx_q;
  logic [ITAG_W-1:0]  itag_q;
  logic [SEL_W-1:0]   wsel_q;
  logic [ADDR_W-1:0]  own_addr, victim_addr;

  assign idx_q    = addr_q[OFF_W +: IDX_W];
  assign tag_q    = addr_q[ADDR_W-1 -: TAG_W];
  assign iidx_q   = addr_q[OFF_W +: IIDX_W];
  assign itag_q   = addr_q[ADDR_W-1 -: ITAG_W];
  assign wsel_q   = addr_q[2 +: SEL_W];

  // tag arrays
  logic [TAG_W-1:0]  t_tag;
  logic              t_valid;
  logic              t_we, t_wvalid;
  logic [ITAG_W-1:0] it_tag;
  logic              it_valid;
  logic              it_we, it_wvalid;

  dcm_tag_store #(.ENTRIES(LINES), .TAG_W(TAG_W)) i_dtags (
    .clk(clk), .rst(rst), .rd_idx(idx_q), .rd_tag(t_tag), .rd_valid(t_valid),
    .wr_en(t_we), .wr_idx(idx_q), .wr_tag(tag_q), .wr_valid(t_wvalid)
  );

  dcm_tag_store #(.ENTRIES(ILINES), .TAG_W(ITAG_W)) i_itags (
    .clk(clk), .rst(rst), .rd_idx(iidx_q), .rd_tag(it_tag), .rd_valid(it_valid),
    .wr_en(it_we), .wr_idx(iidx_q), .wr_tag(itag_q), .wr_valid(it_wvalid)
  );

  assign own_addr    = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign victim_addr = {t_tag, idx_q, {OFF_W{1'b0}}};

  // data array
  logic              accept;
  logic              ram_we;
  logic [LINE_W-1:0] ram_wdata, rd_line, base_line, merged_line;

  assign accept = (st == ST_IDLE) && req_valid;

  dcm_line_ram #(.DEPTH(LINES), .WIDTH(LINE_W)) i_lines (
    .clk(clk), .we(ram_we), .waddr(idx_q), .wdata(ram_wdata),
    .re(accept), .raddr(req_addr[OFF_W +: IDX_W]), .rdata(rd_line)
  );

  assign base_line = (st == ST_FILL) ? mem_rdata : rd_line;

  dcm_word_merge #(.WORDS(WORDS), .WORD_W(WORD_W)) i_merge (
    .line_in(base_line), .word_in(wdata_q), .sel(wsel_q),
    .en(op_q == OP_STORE), .line_out(merged_line)
  );

  logic [WORD_W-1:0] base_word;
  assign base_word = base_line[wsel_q*WORD_W +: WORD_W];

  // lookup outcome
  logic hit, ihit, victim_dirty, ack_ok;
  assign hit          = t_valid && (t_tag == tag_q);
  assign ihit         = it_valid && (it_tag == itag_q);
  assign victim_dirty = t_valid && dirty_q[idx_q];
  assign ack_ok       = mem_ack && mem_req;

  logic              d_we, d_val;
  logic              finish, go_wb, go_fill;
  logic [ADDR_W-1:0] wb_addr;

  always_comb begin
    ram_we    = 1'b0;
    ram_wdata = merged_line;
    t_we      = 1'b0;
    t_wvalid  = 1'b1;
    it_we     = 1'b0;
    it_wvalid = 1'b0;
    d_we      = 1'b0;
    d_val     = 1'b0;
    finish    = 1'b0;
    go_wb     = 1'b0;
    go_fill   = 1'b0;
    wb_addr   = own_addr;
    case (st)
      ST_LOOK: begin
        case (op_q)
          OP_LOAD, OP_TOUCH, OP_STORE: begin
            if (hit) begin
              finish = 1'b1;
              if (op_q == OP_STORE) begin
                ram_we = 1'b1;
                d_we   = 1'b1;
                d_val  = 1'b1;
              end
            end else if (victim_dirty) begin
              go_wb   = 1'b1;
              wb_addr = victim_addr;
            end else begin
              go_fill = 1'b1;
            end
          end
          OP_ZERO: begin
            if (hit || !victim_dirty) begin
              ram_we    = 1'b1;
              ram_wdata = '0;
              t_we      = 1'b1;
              d_we      = 1'b1;
              d_val     = 1'b1;
              finish    = 1'b1;
            end else begin
              go_wb   = 1'b1;
              wb_addr = victim_addr;
            end
          end
          OP_CLEAN: begin
            if (hit && dirty_q[idx_q]) go_wb = 1'b1;
            else finish = 1'b1;
          end
          OP_FLUSH: begin
            if (hit && dirty_q[idx_q]) begin
              go_wb = 1'b1;
            end else begin
              if (hit) begin
                t_we     = 1'b1;
                t_wvalid = 1'b0;
              end
              finish = 1'b1;
            end
          end
          OP_IINV: begin
            it_we     = ihit;
            it_wvalid = 1'b0;
            finish    = 1'b1;
          end
          OP_IPROBE: begin
            it_we     = !ihit;
            it_wvalid = 1'b1;
            finish    = 1'b1;
          end
          default: finish = 1'b1;
        endcase
      end
      ST_WB: begin
        if (ack_ok) begin
          case (op_q)
            OP_LOAD, OP_STORE, OP_TOUCH: go_fill = 1'b1;
            OP_ZERO: begin
              ram_we    = 1'b1;
              ram_wdata = '0;
              t_we      = 1'b1;
              d_we      = 1'b1;
              d_val     = 1'b1;
              finish    = 1'b1;
            end
            OP_CLEAN: begin
              d_we   = 1'b1;
              finish = 1'b1;
            end
            OP_FLUSH: begin
              t_we     = 1'b1;
              t_wvalid = 1'b0;
              d_we     = 1'b1;
              finish   = 1'b1;
            end
            default: finish = 1'b1;
          endcase
        end
      end
      ST_FILL: begin
        if (ack_ok) begin
          ram_we = 1'b1;
          t_we   = 1'b1;
          d_we   = 1'b1;
          d_val  = (op_q == OP_STORE);
          finish = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      op_q      <= OP_LOAD;
      addr_q    <= '0;
      wdata_q   <= '0;
      dirty_q   <= '0;
      busy      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_hit   <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (d_we) dirty_q[idx_q] <= d_val;
      if (accept) begin
        op_q    <= dcm_op_e'(req_op);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        busy    <= 1'b1;
        st      <= ST_LOOK;
      end
      if (st == ST_LOOK)
        rsp_hit <= (op_q == OP_IINV || op_q == OP_IPROBE) ? ihit : hit;
      if (ack_ok) mem_req <= 1'b0;
      if (go_wb) begin
        mem_req   <= 1'b1;
        mem_we    <= 1'b1;
        mem_addr  <= wb_addr;
        mem_wdata <= rd_line;
        st        <= ST_WB;
      end
      if (go_fill) begin
        mem_req  <= 1'b1;
        mem_we   <= 1'b0;
        mem_addr <= own_addr;
        st       <= ST_FILL;
      end
      if (finish) begin
        st        <= ST_IDLE;
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        if (op_q == OP_LOAD) rsp_rdata <= base_word;
      end
    end
  end
endmodule

// File: rtl/dcache_maint_chk.sv
module dcache_maint_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              rsp_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d && !rst)
      assert_reset_R1: assert (!busy && !rsp_valid && !mem_req);
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid && !busy |=> busy);
  assert_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);
  assert_mem_in_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  assert_mem_align_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[OFF_W-1:0] == '0);
endmodule

bind dcache_maint dcache_maint_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy), .rsp_valid(rsp_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/test_dcache_maint.sv
module test_dcache_maint;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [2:0]   req_op = 3'd0;
  logic [31:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         busy, rsp_valid, rsp_hit, mem_req, mem_we;
  logic [31:0]  rsp_rdata, mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcache_maint i_dcache_maint (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_tests = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0;
  logic [31:0]  last_wr_addr;
  logic [127:0] last_wr_data;
  logic [127:0] store_mem [logic [31:0]];
  bit finished = 0;

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [127:0] line_of(logic [31:0] a);
    logic [127:0] l;
    if (store_mem.exists(a)) return store_mem[a];
    for (int i = 0; i < 4; i++) l[i*32 +: 32] = (a + 32'(i*4)) ^ 32'hC0DE_0000;
    return l;
  endfunction

  // memory model: answers after three cycles of request
  initial begin
    int wait_cnt = 0;
    logic [31:0] first_addr = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req && !rst) begin
        if (wait_cnt == 0) first_addr = mem_addr;
        wait_cnt++;
        if (wait_cnt == 3) begin
          wait_cnt = 0;
          check("R11 address held", mem_addr, first_addr);
          check("R11 address aligned", mem_addr[3:0], 4'h0);
          if (mem_we) begin
            store_mem[mem_addr] = mem_wdata;
            n_wr++;
            last_wr_addr = mem_addr;
            last_wr_data = mem_wdata;
          end else begin
            mem_rdata = line_of(mem_addr);
            n_rd++;
          end
          mem_ack = 1'b1;
        end
      end
    end
  end

  logic [31:0] got_rdata;
  logic got_hit, saw_busy, pulse_one;
  int d_rd, d_wr;

  task automatic do_req(logic [2:0] op, logic [31:0] a, logic [31:0] wd);
    int r0, w0;
    @(negedge clk);
    while (busy) @(negedge clk);
    r0 = n_rd; w0 = n_wr;
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    saw_busy = busy;
    while (!rsp_valid) @(negedge clk);
    got_rdata = rsp_rdata; got_hit = rsp_hit;
    @(negedge clk);
    pulse_one = !rsp_valid;
    d_rd = n_rd - r0; d_wr = n_wr - w0;
  endtask

  task automatic t_reset;
    check("R1 busy after reset", busy, 0);
    check("R1 rsp_valid after reset", rsp_valid, 0);
    check("R1 mem_req after reset", mem_req, 0);
  endtask

  task automatic t_load;
    do_req(3'd0, 32'h104, 0);
    check("R2 busy after accept", saw_busy, 1);
    check("R2 single-cycle response", pulse_one, 1);
    check("R1 first access misses", got_hit, 0);
    check("R3 miss reads one line", d_rd, 1);
    check("R3 miss data", got_rdata, 32'hC0DE_0104);
    do_req(3'd0, 32'h10C, 0);
    check("R3 hit flag", got_hit, 1);
    check("R3 hit no memory read", d_rd, 0);
    check("R3 hit data", got_rdata, 32'hC0DE_010C);
  endtask

  task automatic t_store_evict;
    do_req(3'd1, 32'h18, 32'hDEAD_BEEF);
    check("R4 store allocates by reading", d_rd, 1);
    do_req(3'd0, 32'h18, 0);
    check("R4 load after store", got_rdata, 32'hDEAD_BEEF);
    do_req(3'd0, 32'h1014, 0);
    check("R5 dirty victim written", d_wr, 1);
    check("R5 victim address", last_wr_addr, 32'h10);
    check("R5 victim data", last_wr_data[95:64], 32'hDEAD_BEEF);
    check("R5 new line read", got_rdata, 32'hC0DE_1014);
    do_req(3'd0, 32'h18, 0);
    check("R5 clean victim not written", d_wr, 0);
    check("R5 data back from memory", got_rdata, 32'hDEAD_BEEF);
  endtask

  task automatic t_touch;
    do_req(3'd2, 32'h20, 0);
    check("R6 touch reads line", d_rd, 1);
    check("R6 touch writes nothing", d_wr, 0);
    do_req(3'd0, 32'h28, 0);
    check("R6 touched line hits", got_hit, 1);
    check("R6 touched data unchanged", got_rdata, 32'hC0DE_0028);
    do_req(3'd0, 32'h1020, 0);
    check("R6 touched line evicted without write", d_wr, 0);
  endtask

  task automatic t_zero;
    do_req(3'd3, 32'h30, 0);
    check("R7 zero miss no read", d_rd, 0);
    do_req(3'd0, 32'h3C, 0);
    check("R7 zeroed word", got_rdata, 32'h0);
    check("R7 zeroed line present", got_hit, 1);
    do_req(3'd4, 32'h30, 0);
    check("R7 zeroed line dirty", d_wr, 1);
    check("R7 zeros written", last_wr_data, 128'h0);
  endtask

  task automatic t_clean;
    do_req(3'd1, 32'h44, 32'h1234_5678);
    do_req(3'd4, 32'h40, 0);
    check("R8 clean writes once", d_wr, 1);
    check("R8 clean address", last_wr_addr, 32'h40);
    check("R8 clean data", last_wr_data[63:32], 32'h1234_5678);
    do_req(3'd0, 32'h44, 0);
    check("R8 line stays valid", got_hit, 1);
    check("R8 no read after clean", d_rd, 0);
    do_req(3'd4, 32'h40, 0);
    check("R8 second clean no write", d_wr, 0);
    do_req(3'd4, 32'h1040, 0);
    check("R8 clean miss no traffic", d_wr + d_rd, 0);
  endtask

  task automatic t_flush;
    do_req(3'd1, 32'h50, 32'hCAFE_F00D);
    do_req(3'd5, 32'h50, 0);
    check("R9 flush writes dirty line", d_wr, 1);
    check("R9 flush address", last_wr_addr, 32'h50);
    do_req(3'd0, 32'h50, 0);
    check("R9 flushed line misses", got_hit, 0);
    check("R9 refetched data", got_rdata, 32'hCAFE_F00D);
    do_req(3'd5, 32'h54, 0);
    check("R9 clean flush no write", d_wr, 0);
    do_req(3'd0, 32'h54, 0);
    check("R9 clean flush invalidates", got_hit, 0);
  endtask

  task automatic t_icache;
    do_req(3'd7, 32'h60, 0);
    check("R10 probe first miss", got_hit, 0);
    do_req(3'd7, 32'h64, 0);
    check("R10 probe allocated", got_hit, 1);
    do_req(3'd6, 32'h2060, 0);
    check("R10 invalidate other tag misses", got_hit, 0);
    do_req(3'd7, 32'h68, 0);
    check("R10 other tag kept block", got_hit, 1);
    do_req(3'd6, 32'h68, 0);
    check("R10 invalidate reports present", got_hit, 1);
    check("R10 no memory traffic", d_rd + d_wr, 0);
    do_req(3'd7, 32'h60, 0);
    check("R10 block removed", got_hit, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load();
    t_store_evict();
    t_touch();
    t_zero();
    t_clean();
    t_flush();
    t_icache();
    finish_run();
  end
endmodule